// File: doc/BRIEF.md
# Delayed Read Forwarding Controller

This block sits inside a two-port bus bridge, between the interface where an initiator's read is captured and the master interface that later fetches the data from the far side. Every read is forwarded as a delayed transaction: the captured request is turned into one outbound fetch request, and the data is returned to the initiator afterwards.

For each captured read, the block looks at the 4-bit command code and at a flag saying whether the address falls in prefetchable memory. From these it picks one of two fetch styles:

- **Prefetching burst.** All byte enables are forced on. The length is the smallest of three values: a per-command nominal length, the free buffer space, and the DWORDs left before the next 4 KB address boundary. The length is never less than one.
- **Single-DWORD fetch.** The initiator's byte enables are kept unchanged. When the first DWORD is handed back to the initiator, the block signals a disconnect.

Command codes outside the five supported reads are flagged as unsupported and dropped.

Top module: `rd_fwd_ctrl`

## Requirements
- R1: Command 1110 (memory read line) and 1100 (memory read multiple) are always issued with `out_prefetch`=1. Command 0110 (memory read) is issued with `out_prefetch`=1 when `req_pref_space`=1.
- R2: Command 0010 (I/O read) and 1010 (configuration read) are always issued with `out_prefetch`=0. Command 0110 is issued with `out_prefetch`=0 when `req_pref_space`=0.
- R3: A prefetching request drives `out_be`=4'b1111, whatever `req_be` held.
- R4: A non-prefetching request drives `out_dw_cnt`=1 and `out_be` equal to the captured `req_be`.
- R5: A prefetching request's `out_dw_cnt` is the minimum of three values, forced to 1 if that minimum is 0:
  - the nominal length: LINE_DW (8) for 1110 and prefetchable 0110, and MRM_LINES*LINE_DW (16) for 1100;
  - `free_dw` at the moment of capture;
  - 1024 minus address bits [11:2].
- R6: Any other command code is accepted, raises `req_unsup` for exactly the one cycle after capture, and produces no outbound request.
- R7: A request is captured on a clock edge with `req_valid`=1 and `req_ready`=1, and appears on the outbound side in the next cycle. While `out_valid`=1, `req_ready` is 0, and all outbound fields hold steady until a cycle with `out_ready`=1 issues the request.
- R8: After a non-prefetching request issues, the first `ini_xfer` drives `ini_disc`=1 in that same cycle. Later transfers do not. A prefetching completion never drives `ini_disc`; it ends on `ini_end`.
- R9: The completion class is taken from each issued request. If an issue and a DWORD delivery fall in the same cycle, `ini_disc` follows the earlier request, and the new request's class applies from the next cycle on.
- R10: After reset, `req_ready`=1, `out_valid`=0 and `req_unsup`=0, and no completion is pending, so `ini_xfer` gives `ini_disc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Captured read request present |
| req_ready | output | 1 | Block can take a request |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | ADDR_W | Request byte address |
| req_be | input | 4 | Initiator byte enables, active high |
| req_pref_space | input | 1 | Address lies in prefetchable memory |
| free_dw | input | FREE_W | Free read buffer space in DWORDs |
| out_valid | output | 1 | Outbound fetch request present |
| out_ready | input | 1 | Master side takes the request |
| out_addr | output | ADDR_W | Fetch address |
| out_be | output | 4 | Fetch byte enables |
| out_dw_cnt | output | CNT_W | Number of DWORDs to fetch |
| out_prefetch | output | 1 | Fetch is a prefetching burst |
| req_unsup | output | 1 | One-cycle flag for an unsupported command |
| ini_xfer | input | 1 | A read DWORD is handed to the initiator |
| ini_end | input | 1 | Initiator ends a prefetching completion |
| ini_disc | output | 1 | Disconnect the initiator now |

## Verification
Two functions can fall in the same cycle: issuing a new outbound request, and handing the first DWORD of the previous completion to the initiator. The bench first issues a single-DWORD read and leaves its completion pending. It then captures a prefetching read, and raises `out_ready` and `ini_xfer` together. The disconnect must follow the old request in that cycle. In the following cycle, another transfer must not disconnect, because the new burst class now applies. The classification, length clipping and byte-enable rules are judged from a vector table covering every supported code, both space settings, free-space and boundary clipping, and the zero-space floor.

// File: rtl/rd_fwd_ctrl.sv
module rd_fwd_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int LINE_DW     = 8,
  parameter int MRM_LINES   = 2,
  parameter int BOUND_BYTES = 4096,
  parameter int FREE_W      = 8,
  localparam int CNT_W      = $clog2(MRM_LINES * LINE_DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic              req_pref_space,
  input  logic [FREE_W-1:0] free_dw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [3:0]        out_be,
  output logic [CNT_W-1:0]  out_dw_cnt,
  output logic              out_prefetch,
  output logic              req_unsup,
  input  logic              ini_xfer,
  input  logic              ini_end,
  output logic              ini_disc
);

  localparam logic [3:0] C_IORD  = 4'b0010;
  localparam logic [3:0] C_MRD   = 4'b0110;
  localparam logic [3:0] C_CFGRD = 4'b1010;
  localparam logic [3:0] C_MRM   = 4'b1100;
  localparam logic [3:0] C_MRL   = 4'b1110;

  localparam int BOUND_DW = BOUND_BYTES / 4;
  localparam int OFF_W    = $clog2(BOUND_DW);

  logic accept, issue, supported, is_pf;
  logic [31:0] nom_len, room_len, free_len, pf_len;
  logic [CNT_W-1:0] cnt_next;
  logic cmp_act, cmp_pf;

  assign req_ready = !out_valid;
  assign accept    = req_valid && req_ready;
  assign issue     = out_valid && out_ready;
  assign ini_disc  = cmp_act && !cmp_pf && ini_xfer;

  always_comb begin
    supported = 1'b1;
    is_pf     = 1'b0;
    nom_len   = 32'(LINE_DW);
    case (req_cmd)
      C_MRL:   is_pf = 1'b1;
      C_MRM:   begin is_pf = 1'b1; nom_len = 32'(MRM_LINES * LINE_DW); end
      C_MRD:   is_pf = req_pref_space;
      C_IORD, C_CFGRD: is_pf = 1'b0;
      default: supported = 1'b0;
    endcase
  end

  always_comb begin
    free_len = 32'(free_dw);
    room_len = 32'(BOUND_DW) - 32'(req_addr[OFF_W+1:2]);
    pf_len   = nom_len;
    if (free_len < pf_len) pf_len = free_len;
    if (room_len < pf_len) pf_len = room_len;
    if (pf_len == 32'd0)   pf_len = 32'd1;
    cnt_next = is_pf ? CNT_W'(pf_len) : CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_be       <= '0;
      out_dw_cnt   <= '0;
      out_prefetch <= 1'b0;
      req_unsup    <= 1'b0;
    end else begin
      req_unsup <= accept && !supported;
      if (accept && supported) begin
        out_valid    <= 1'b1;
        out_addr     <= req_addr;
        out_be       <= is_pf ? 4'b1111 : req_be;
        out_dw_cnt   <= cnt_next;
        out_prefetch <= is_pf;
      end else if (issue) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= 1'b0;
      cmp_pf  <= 1'b0;
    end else if (issue) begin
      cmp_act <= 1'b1;
      cmp_pf  <= out_prefetch;
    end else if (cmp_act && ((!cmp_pf && ini_xfer) || (cmp_pf && ini_end))) begin
      cmp_act <= 1'b0;
    end
  end

  p_line_multi_pf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_cmd == C_MRL || req_cmd == C_MRM) |=> out_valid && out_prefetch);

  p_io_cfg_np_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (req_cmd == C_IORD || req_cmd == C_CFGRD) |=> out_valid && !out_prefetch);

  p_pf_be_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefetch |-> out_be == 4'b1111);

  p_np_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_cmd == C_IORD |=> out_dw_cnt == CNT_W'(1) && out_be == $past(req_be));

  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dw_cnt >= CNT_W'(1) && 32'(out_dw_cnt) <= MRM_LINES * LINE_DW);

  p_unsup_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_unsup |-> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
                                && $stable(out_dw_cnt) && $stable(out_prefetch));

  p_disc_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ini_disc && !issue |=> !ini_disc);

endmodule

// File: tb/rd_fwd_ctrl_tb.sv
module rd_fwd_ctrl_tb;
  localparam int CNT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, out_ready = 0, ini_xfer = 0, ini_end = 0, req_pref_space = 0;
  logic [3:0] req_cmd = 0, req_be = 0;
  logic [31:0] req_addr = 0;
  logic [7:0] free_dw = 0;
  logic req_ready, out_valid, out_prefetch, req_unsup, ini_disc;
  logic [31:0] out_addr;
  logic [3:0] out_be;
  logic [CNT_W-1:0] out_dw_cnt;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  rd_fwd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
    .req_pref_space(req_pref_space), .free_dw(free_dw), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_be(out_be),
    .out_dw_cnt(out_dw_cnt), .out_prefetch(out_prefetch), .req_unsup(req_unsup),
    .ini_xfer(ini_xfer), .ini_end(ini_end), .ini_disc(ini_disc));

  // cmd, addr, be, pref_space, free, exp_unsup, exp_pf, exp_be, exp_cnt
  localparam int NV = 13;
  localparam logic [62:0] VECS [NV] = '{
    {4'b1110, 32'h0000_1000, 4'h3, 1'b0, 8'd64, 1'b0, 1'b1, 4'hF, 8'd8},   // R1 R3
    {4'b1100, 32'h0000_2000, 4'h1, 1'b0, 8'd64, 1'b0, 1'b1, 4'hF, 8'd16},  // R1 R5
    {4'b0110, 32'h0000_3000, 4'h6, 1'b1, 8'd64, 1'b0, 1'b1, 4'hF, 8'd8},   // R1
    {4'b0110, 32'h0000_3004, 4'h5, 1'b0, 8'd64, 1'b0, 1'b0, 4'h5, 8'd1},   // R2 R4
    {4'b0010, 32'h0000_0040, 4'h2, 1'b1, 8'd64, 1'b0, 1'b0, 4'h2, 8'd1},   // R2 R4
    {4'b1010, 32'h0000_0010, 4'hC, 1'b1, 8'd0,  1'b0, 1'b0, 4'hC, 8'd1},   // R2 R4
    {4'b1100, 32'h0000_4000, 4'h0, 1'b0, 8'd5,  1'b0, 1'b1, 4'hF, 8'd5},   // R5 free
    {4'b1100, 32'h0000_0FF8, 4'hF, 1'b0, 8'd64, 1'b0, 1'b1, 4'hF, 8'd2},   // R5 boundary
    {4'b1110, 32'h0000_5000, 4'h8, 1'b0, 8'd0,  1'b0, 1'b1, 4'hF, 8'd1},   // R5 floor
    {4'b1100, 32'h0001_0FFC, 4'h1, 1'b0, 8'd64, 1'b0, 1'b1, 4'hF, 8'd1},   // R5 last dword
    {4'b0110, 32'h0000_0FE0, 4'h0, 1'b1, 8'd3,  1'b0, 1'b1, 4'hF, 8'd3},   // R5 free wins
    {4'b0000, 32'h0000_0100, 4'hF, 1'b0, 8'd64, 1'b1, 1'b0, 4'h0, 8'd0},   // R6
    {4'b0111, 32'h0000_0200, 4'hF, 1'b1, 8'd64, 1'b1, 1'b0, 4'h0, 8'd0}    // R6
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic capture(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                         input logic ps, input logic [7:0] f);
    @(negedge clk);
    req_cmd = c; req_addr = a; req_be = b; req_pref_space = ps; free_dw = f;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic issue_now();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    ini_xfer = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
    chk(ini_disc == 1'b0, "R10", "disc in reset", ini_disc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(req_unsup == 1'b0, "R10", "unsup after reset", req_unsup, 0);
    chk(ini_disc == 1'b0, "R10", "no pending completion", ini_disc, 0);
    ini_xfer = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VECS[i];
      capture(v[62:59], v[58:27], v[26:23], v[22], v[21:14]);
      if (v[13]) begin
        chk(req_unsup == 1'b1, "R6", $sformatf("unsup flag vec%0d", i), req_unsup, 1);
        chk(out_valid == 1'b0, "R6", $sformatf("no request vec%0d", i), out_valid, 0);
        @(negedge clk);
        chk(req_unsup == 1'b0, "R6", $sformatf("flag one cycle vec%0d", i), req_unsup, 0);
        chk(out_valid == 1'b0, "R6", $sformatf("still no request vec%0d", i), out_valid, 0);
      end else begin
        chk(out_valid == 1'b1, "R7", $sformatf("valid vec%0d", i), out_valid, 1);
        chk(out_prefetch == v[12], v[12] ? "R1" : "R2",
            $sformatf("class vec%0d", i), out_prefetch, v[12]);
        chk(out_be == v[11:8], v[12] ? "R3" : "R4",
            $sformatf("byte enables vec%0d", i), out_be, v[11:8]);
        chk(8'(out_dw_cnt) == v[7:0], v[12] ? "R5" : "R4",
            $sformatf("count vec%0d", i), out_dw_cnt, v[7:0]);
        chk(out_addr == v[58:27], "R7", $sformatf("addr vec%0d", i), out_addr, v[58:27]);
        chk(req_ready == 1'b0, "R7", $sformatf("busy vec%0d", i), req_ready, 0);
        // A second request offered while busy must not disturb the held one
        req_cmd = 4'b0010; req_be = 4'h9; req_addr = 32'hDEAD_0000; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid == 1'b1 && out_be == v[11:8] && 8'(out_dw_cnt) == v[7:0]
            && out_addr == v[58:27], "R7", $sformatf("hold vec%0d", i), out_be, v[11:8]);
        issue_now();
        chk(out_valid == 1'b0 && req_ready == 1'b1, "R7",
            $sformatf("issued vec%0d", i), out_valid, 0);
        ini_end = 1'b1; ini_xfer = 1'b1;
        @(negedge clk);
        ini_end = 1'b0; ini_xfer = 1'b0;
      end
    end

    // R8 non-prefetch completion disconnects on first DWORD only
    capture(4'b0010, 32'h80, 4'h1, 1'b0, 8'd64);
    issue_now();
    ini_xfer = 1'b1;
    #1;
    chk(ini_disc == 1'b1, "R8", "disc on first dword", ini_disc, 1);
    @(negedge clk);
    chk(ini_disc == 1'b0, "R8", "no disc after first", ini_disc, 0);
    ini_xfer = 1'b0;

    // R8 prefetch completion never disconnects
    capture(4'b1110, 32'h100, 4'h1, 1'b0, 8'd64);
    issue_now();
    ini_xfer = 1'b1;
    #1;
    chk(ini_disc == 1'b0, "R8", "prefetch no disc", ini_disc, 0);
    @(negedge clk);
    chk(ini_disc == 1'b0, "R8", "prefetch no disc 2", ini_disc, 0);
    ini_xfer = 1'b0; ini_end = 1'b1;
    @(negedge clk);
    ini_end = 1'b0;

    // R9 issue and first delivery in the same cycle
    capture(4'b1010, 32'h20, 4'h3, 1'b0, 8'd64);
    issue_now();
    capture(4'b1100, 32'h400, 4'h3, 1'b0, 8'd64);
    out_ready = 1'b1; ini_xfer = 1'b1;
    #1;
    chk(ini_disc == 1'b1, "R9", "old class in shared cycle", ini_disc, 1);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(ini_disc == 1'b0, "R9", "new prefetch class applies", ini_disc, 0);
    chk(out_valid == 1'b0, "R9", "new request issued", out_valid, 0);
    ini_xfer = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule